// File: doc/BRIEF.md
# Eight-Channel Shared-Rise PWM Generator

This block drives a vector of pulse-width-modulated outputs without any per-channel compare register. It keeps one shared up-counter that sets the rising edge of every channel, plus one free-running down-counter per channel that sets that channel's falling edge. Every step enable moves all counters by one. The shared counter wraps from its maximum to zero and turns every channel on. A channel counter that steps from one to zero turns its own channel off. The duty of a channel is the phase offset between its counter and the shared counter, and this offset does not change while the block runs.

Software or a sequencer sets the duty by writing a counter through a single preload port, one counter per cycle. The period is fixed at 2^CW steps (256 with the default width). A channel's high time per period equals the sum of its counter and the shared counter, modulo 2^CW. The whole output vector is registered and changes as one word on the step that caused the change.

Top module: `shared_rise_pwm`

## Requirements
- R1: Reset (synchronous, active high `rst`) clears every output bit and every counter. After reset, stepping alone keeps all outputs low, because every offset is zero.
- R2: On a cycle with `step_en` high, each channel counter decrements by one modulo 256 and the shared counter increments by one modulo 256. Any resulting output change appears on `pwm_out` after that same clock edge.
- R3: A channel whose counter steps from 1 to 0 drives its `pwm_out` bit low.
- R4: The step on which the shared counter goes from 255 to 0 drives every `pwm_out` bit high, apart from the channels covered by R5.
- R5: A channel whose counter steps from 1 to 0 on the same step as the shared wrap stays low after that step, whatever its previous level.
- R6: Once a shared wrap has occurred, every window of 256 consecutive steps holds channel i high for exactly (channel counter i + shared counter) mod 256 steps. An offset of 0 never goes high, and an offset of 255 goes high for 255 of 256 steps.
- R7: With `step_en` low and no preload, no counter and no output changes.
- R8: With `load_en` high, `load_sel` values 0 to 7 write channel counter `load_sel`, value 8 writes the shared counter, and values 9 to 15 write nothing. The written counter takes `load_val` and neither steps nor raises an event in that cycle. The preload itself does not change `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advances all counters by one step |
| load_en | input | 1 | Preload strobe |
| load_sel | input | 4 | Counter to write: 0..7 channel, 8 shared |
| load_val | input | 8 | Value written into the selected counter |
| pwm_out | output | 8 | PWM output vector, bit i is channel i |

## Verification
The shared wrap that raises every channel and a channel's own counter reaching zero can fall on the same step. The bench provokes this by preloading the shared counter to 255 and a channel counter to 1 while that channel is high, then issuing one step. It expects that channel low and the channels with a non-zero offset high. A second coincidence arises from an offset of zero, which must keep the channel low over full periods. A cycle that preloads a counter while `step_en` is high is also driven, and the stepping of the other counters is judged against the scoreboard.

// File: rtl/shared_rise_pwm.sv
module shared_rise_pwm #(
  parameter int CHANNELS = 8,
  parameter int CW       = 8,
  localparam int SW      = $clog2(CHANNELS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  logic                load_en,
  input  logic [SW-1:0]       load_sel,
  input  logic [CW-1:0]       load_val,
  output logic [CHANNELS-1:0] pwm_out
);

  localparam logic [SW-1:0] SHARED_SEL = SW'(CHANNELS);
  localparam logic [CW-1:0] CNT_MAX    = '1;
  localparam logic [CW-1:0] CNT_ONE    = CW'(1);

  logic [CW-1:0]       rise_cnt;
  logic [CHANNELS-1:0] fall_hit;
  logic [CHANNELS-1:0] pwm_q;

  wire shared_ld = load_en && (load_sel == SHARED_SEL);
  wire wrap      = step_en && !shared_ld && (rise_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)            rise_cnt <= '0;
    else if (shared_ld) rise_cnt <= load_val;
    else if (step_en)   rise_cnt <= rise_cnt + CNT_ONE;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [CW-1:0] cnt;
    wire ld = load_en && (load_sel == SW'(i));

    assign fall_hit[i] = step_en && !ld && (cnt == CNT_ONE);

    always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (ld)      cnt <= load_val;
      else if (step_en) cnt <= cnt - CNT_ONE;
    end

    // R3
    fall_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_q[i]) |-> (cnt == '0));

    // R5
    coincide_low_chk: assert property (@(posedge clk) disable iff (rst)
      (wrap && fall_hit[i]) |=> !pwm_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)       pwm_q <= '0;
    else if (wrap) pwm_q <= ~fall_hit;
    else           pwm_q <= pwm_q & ~fall_hit;
  end

  assign pwm_out = pwm_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pwm_out == '0 && rise_cnt == '0));

  // R4
  rise_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pwm_q & ~$past(pwm_q))) |-> (rise_cnt == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> ($stable(pwm_q) && $stable(rise_cnt)));

  // R8
  load_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_en && load_en) |=> $stable(pwm_q));

endmodule

// File: tb/tb_shared_rise_pwm.sv
module tb_shared_rise_pwm;
  localparam int N = 8;

  logic       clk = 0;
  logic       rst = 1;
  logic       step_en = 0;
  logic       load_en = 0;
  logic [3:0] load_sel = 0;
  logic [7:0] load_val = 0;
  logic [7:0] pwm_out;

  shared_rise_pwm dut (.clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
                       .load_sel(load_sel), .load_val(load_val), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_ch [N];
  int m_rise;
  logic [7:0] m_out;

  logic [7:0] q_exp [$];
  string      q_tag [$];
  bit         q_tl  [$];
  int         hi_cnt [N];

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      bit tl;
      e = q_exp.pop_front(); t = q_tag.pop_front(); tl = q_tl.pop_front();
      tests++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", t, pwm_out, e);
      end
      if (tl) for (int i = 0; i < N; i++) hi_cnt[i] += int'(pwm_out[i]);
    end
  end

  task automatic drive(input bit st, input bit ld, input int sel, input int val,
                       input string tag, input bit tl = 0);
    logic [7:0] hitv;
    bit wr;
    @(negedge clk);
    step_en = st; load_en = ld; load_sel = 4'(sel); load_val = 8'(val);
    hitv = '0;
    for (int i = 0; i < N; i++)
      if (st && !(ld && sel == i) && m_ch[i] == 1) hitv[i] = 1'b1;
    wr = st && !(ld && sel == N) && m_rise == 255;
    if (wr) m_out = ~hitv; else m_out = m_out & ~hitv;
    for (int i = 0; i < N; i++)
      if (ld && sel == i) m_ch[i] = val;
      else if (st) m_ch[i] = (m_ch[i] + 255) % 256;
    if (ld && sel == N) m_rise = val;
    else if (st) m_rise = (m_rise + 1) % 256;
    q_exp.push_back(m_out); q_tag.push_back(tag); q_tl.push_back(tl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; step_en = 0; load_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < N; i++) m_ch[i] = 0;
    m_rise = 0; m_out = '0;
    tests++;
    if (pwm_out !== 8'h00) begin
      fails++; $display("FAIL R1 reset act=%h exp=00", pwm_out);
    end
  endtask

  task automatic duty_window(input string tag);
    int exp_d [N];
    for (int i = 0; i < N; i++) begin
      exp_d[i] = (m_ch[i] + m_rise) % 256;
      hi_cnt[i] = 0;
    end
    for (int k = 0; k < 256; k++) drive(1, 0, 0, 0, tag, 1);
    drive(0, 0, 0, 0, "R7 drain");
    @(posedge clk); #2;
    for (int i = 0; i < N; i++) begin
      tests++;
      if (hi_cnt[i] != exp_d[i]) begin
        fails++;
        $display("FAIL %s duty ch%0d act=%0d exp=%0d", tag, i, hi_cnt[i], exp_d[i]);
      end
    end
  endtask

  int duties [N] = '{0, 1, 64, 128, 200, 255, 37, 3};

  initial begin
    do_reset();
    drive(0, 0, 0, 0, "R1 idle after reset");
    duty_window("R1 zero offsets");

    for (int i = 0; i < N; i++) drive(0, 1, i, duties[i], "R8 load channel");
    drive(0, 1, N, 0, "R8 load shared");
    drive(0, 1, 12, 99, "R8 ignored select");
    for (int k = 0; k < 256; k++) drive(1, 0, 0, 0, "R2 R3 R4 warmup");
    duty_window("R6");
    for (int k = 0; k < 6; k++) drive(0, 0, 0, 0, "R7 hold");
    for (int k = 0; k < 40; k++) drive(1, 0, 0, 0, "R2 R3 after hold");

    drive(1, 1, 2, 10, "R8 load with step");
    drive(1, 1, N, 250, "R8 shared load with step");
    for (int k = 0; k < 300; k++) drive(1, 0, 0, 0, "R2 R3 R4 run");

    drive(0, 1, N, 255, "R8 preset wrap");
    drive(0, 1, 3, 100, "R8 preset ch3");
    drive(1, 0, 0, 0, "R4 wrap raises ch3");
    drive(0, 1, N, 255, "R8 shared to 255");
    drive(0, 1, 3, 1, "R8 ch3 to 1");
    drive(1, 0, 0, 0, "R5 coincidence");
    drive(0, 0, 0, 0, "R5 settle");
    @(posedge clk); #2;
    tests++;
    if (pwm_out[3] !== 1'b0) begin
      fails++; $display("FAIL R5 ch3 act=%b exp=0", pwm_out[3]);
    end
    for (int k = 0; k < 256; k++) drive(1, 0, 0, 0, "R3 R4 post coincidence");
    duty_window("R6 after reload");

    do_reset();
    drive(1, 0, 0, 0, "R1 step after midrun reset");
    duty_window("R1 after midrun reset");

    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end
endmodule